// File: doc/BRIEF.md
# In-Band Loopback Code Generator and Detector

This block inserts and recognises the repeating loopback codes carried in the payload of a T1-style serial stream. On the transmit side it can replace outgoing data with an activate (loop-up) code or a deactivate (loop-down) code. On the receive side it watches incoming bits for either code and reports a detection. The receiver tolerates a line error ratio of about one bit in a hundred. It also finds the code at any phase offset.

Each code is either a fixed default or a programmed pattern of 2 to 8 bits. In framed operation, the framing-bit slot of each frame is marked by a strobe. The generator passes that slot through unchanged and the detector ignores it. In unframed operation, the code covers every bit and the detector checks every bit.

The transmit path has three states. `TX_PASS` forwards input data. `TX_UP` inserts the loop-up code. `TX_DN` inserts the loop-down code. Each cycle, the next state follows the send controls, and loop-up wins when both are set. Entering a code state from any other state restarts that code at its first bit.

Each detector has two states. It moves from `DET_SEARCH` to `DET_FOUND` at the end of a window in which some phase met the error threshold. It moves from `DET_FOUND` back to `DET_SEARCH` at the end of a window in which no phase met it. It stays where it is at every other bit.

Top module: `lcode_top`

## Requirements
- R1: With `cfg_flex` low, the loop-up code is the 5-bit sequence 0,0,0,0,1 and the loop-down code is the 3-bit sequence 0,0,1, each repeated without gaps. The first bit listed is the first bit sent.
- R2: With `cfg_flex` high, each code has length L taken from its 4-bit length field. Values below 2 are treated as 2 and values above 8 as 8. The code is the low L bits of its 8-bit pattern field, sent from bit L-1 down to bit 0.
- R3: `tx_out_bit` and `tx_out_valid` are registered one cycle after the inputs they follow. `tx_send_up` replaces data with the loop-up code. Otherwise `tx_send_dn` replaces it with the loop-down code. With neither set, `tx_in_bit` passes through.
- R4: The code pointer restarts at the first code bit whenever the selected code changes, and whenever any code length or pattern input changes.
- R5: With `cfg_framed` high, a bit whose `tx_in_fbit` is set passes unchanged and does not advance the code, and a received bit whose `rx_fbit` is set is not checked. With `cfg_framed` low, the strobes are ignored: every bit is coded and every bit is checked.
- R6: Each detector counts checked bits in consecutive windows of 2048, starting from reset. At the end of a window it declares its code if any phase alignment has at most 20 mismatches in that window. Its output never changes between window ends.
- R7: A window in which the best-aligned phase has 21 mismatches does not declare a code.
- R8: A declared code is withdrawn at the end of the first window in which no phase has 20 or fewer mismatches.
- R9: `up_irq` and `dn_irq` set when their detection is declared, and stay set until a one-cycle pulse on `irq_clr_up` or `irq_clr_dn`. If a set and a clear arrive in the same cycle, the set wins.
- R10: After reset, all detection, interrupt and transmit outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_framed | input | 1 | 1: framed operation, 0: unframed |
| cfg_flex | input | 1 | 1: programmed codes, 0: default codes |
| cfg_up_len | input | 4 | Loop-up code length (2..8, clamped) |
| cfg_up_pat | input | 8 | Loop-up code pattern |
| cfg_dn_len | input | 4 | Loop-down code length (2..8, clamped) |
| cfg_dn_pat | input | 8 | Loop-down code pattern |
| tx_send_up | input | 1 | Replace transmit data with loop-up code |
| tx_send_dn | input | 1 | Replace transmit data with loop-down code |
| tx_in_bit | input | 1 | Transmit data bit in |
| tx_in_valid | input | 1 | Transmit bit strobe |
| tx_in_fbit | input | 1 | Transmit bit is in the framing slot |
| tx_out_bit | output | 1 | Transmit data bit out |
| tx_out_valid | output | 1 | Transmit output strobe |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | Received bit strobe |
| rx_fbit | input | 1 | Received bit is in the framing slot |
| up_det | output | 1 | Loop-up code currently declared |
| dn_det | output | 1 | Loop-down code currently declared |
| up_irq | output | 1 | Latched loop-up detection event |
| dn_irq | output | 1 | Latched loop-down detection event |
| irq_clr_up | input | 1 | Clear pulse for `up_irq` |
| irq_clr_dn | input | 1 | Clear pulse for `dn_irq` |

## Verification
A corrupted code pointer or transmit state shows on `tx_out_bit` in the very next cycle as a wrong code bit or a missing restart. The transmit checks therefore compare every output bit against the expected sequence. A faulty mismatch counter, window counter or phase index is silent until a window closes. It then appears as a wrong `up_det` or `dn_det`, up to 2048 checked bits later. For that reason the stimuli are aligned to windows from reset, and they place error counts exactly on and just past the threshold at several phase offsets, in both framing modes.

// File: rtl/lcode_pkg.sv
package lcode_pkg;

    localparam int unsigned CODE_MAX = 8;
    localparam int unsigned LEN_W    = 4;

    typedef struct packed {
        logic [LEN_W-1:0]    len;
        logic [CODE_MAX-1:0] pat;
    } lcode_t;

    typedef enum logic [1:0] {TX_PASS, TX_UP, TX_DN} tx_state_e;
    typedef enum logic       {DET_SEARCH, DET_FOUND} det_state_e;

    localparam lcode_t LC_UP_DEFAULT = '{len: 4'd5, pat: 8'b0000_0001};
    localparam lcode_t LC_DN_DEFAULT = '{len: 4'd3, pat: 8'b0000_0001};

    // clamp a programmed length into the legal 2..CODE_MAX range
    function automatic lcode_t lc_resolve(input logic [LEN_W-1:0] len,
                                          input logic [CODE_MAX-1:0] pat);
        lcode_t c;
        c.pat = pat;
        if (len < 4'd2)
            c.len = 4'd2;
        else if (len > LEN_W'(CODE_MAX))
            c.len = LEN_W'(CODE_MAX);
        else
            c.len = len;
        return c;
    endfunction

    // bit number idx of the code in send order (pattern MSB of the used part first)
    function automatic logic lc_bit(input lcode_t c, input logic [LEN_W-1:0] idx);
        logic [LEN_W-1:0] k;
        k = c.len - 4'd1 - idx;
        return c.pat[k[2:0]];
    endfunction

endpackage

// File: rtl/lcode_phase.sv
module lcode_phase #(
    parameter int unsigned THRESH = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic chk,
    input  logic win_end,
    input  logic active,
    input  logic miss,
    output logic hit
);
    localparam int unsigned CNT_W = $clog2(THRESH + 2);
    localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(THRESH);
    localparam logic [CNT_W:0] SAT   = (CNT_W+1)'(THRESH + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, cnt} + {{CNT_W{1'b0}}, miss};
    assign hit = active && (sum <= LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (chk) begin
            if (win_end)
                cnt <= '0;
            else if (sum > SAT)
                cnt <= SAT[CNT_W-1:0];
            else
                cnt <= sum[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/lcode_tx.sv
module lcode_tx
    import lcode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   framed,
    input  lcode_t up_code,
    input  lcode_t dn_code,
    input  logic   send_up,
    input  logic   send_dn,
    input  logic   in_bit,
    input  logic   in_valid,
    input  logic   in_fbit,
    output logic   out_bit,
    output logic   out_valid
);
    tx_state_e        st, st_nx;
    lcode_t           cur;
    lcode_t           up_q, dn_q;
    logic             cfg_chg, restart, coded, take;
    logic [LEN_W-1:0] ptr, ptr_eff, ptr_inc, ptr_nx;

    always_comb begin
        if (send_up)
            st_nx = TX_UP;
        else if (send_dn)
            st_nx = TX_DN;
        else
            st_nx = TX_PASS;
    end

    always_comb begin
        unique case (st_nx)
            TX_UP:   cur = up_code;
            TX_DN:   cur = dn_code;
            default: cur = up_code;
        endcase
    end

    assign cfg_chg = (up_code != up_q) || (dn_code != dn_q);
    assign restart = cfg_chg || (st_nx != st);
    assign ptr_eff = restart ? '0 : ptr;
    assign coded   = (st_nx != TX_PASS) && !(framed && in_fbit);
    assign take    = in_valid && coded;
    assign ptr_inc = ptr_eff + 4'd1;
    assign ptr_nx  = take ? ((ptr_inc >= cur.len) ? '0 : ptr_inc) : ptr_eff;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= TX_PASS;
        else
            st <= st_nx;
    end

    // pointer, configuration copy and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr       <= '0;
            up_q      <= LC_UP_DEFAULT;
            dn_q      <= LC_DN_DEFAULT;
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            ptr       <= ptr_nx;
            up_q      <= up_code;
            dn_q      <= dn_code;
            out_bit   <= coded ? lc_bit(cur, ptr_eff) : in_bit;
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/lcode_det.sv
module lcode_det
    import lcode_pkg::*;
#(
    parameter int unsigned WINDOW = 2048,
    parameter int unsigned THRESH = 20
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   framed,
    input  lcode_t code,
    input  logic   bit_in,
    input  logic   valid,
    input  logic   fbit,
    input  logic   irq_clr,
    output logic   det,
    output logic   irq
);
    localparam int unsigned WIN_W = $clog2(WINDOW);

    det_state_e       st, st_nx;
    lcode_t           code_q;
    logic             cfg_chg, chk, win_end, win_done, any_hit;
    logic [WIN_W-1:0] wcnt;
    logic [LEN_W-1:0] pos;
    logic [CODE_MAX-1:0] hit;

    assign cfg_chg  = (code != code_q);
    assign chk      = valid && !(framed && fbit);
    assign win_end  = (wcnt == WIN_W'(WINDOW - 1));
    assign win_done = chk && !cfg_chg && win_end;
    assign any_hit  = |hit;

    generate
        for (genvar p = 0; p < CODE_MAX; p++) begin : g_ph
            logic [LEN_W:0]   sum_w;
            logic [LEN_W-1:0] idx_w;
            logic             exp_w;
            always_comb begin
                sum_w = {1'b0, pos} + (LEN_W+1)'(p);
                if (sum_w >= {1'b0, code.len})
                    idx_w = LEN_W'(sum_w - {1'b0, code.len});
                else
                    idx_w = sum_w[LEN_W-1:0];
                exp_w = lc_bit(code, idx_w);
            end
            lcode_phase #(.THRESH(THRESH)) u_ph (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (cfg_chg),
                .chk     (chk),
                .win_end (win_end),
                .active  (LEN_W'(p) < code.len),
                .miss    (bit_in ^ exp_w),
                .hit     (hit[p])
            );
        end
    endgenerate

    // position in code and window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            pos    <= '0;
            wcnt   <= '0;
        end else begin
            code_q <= code;
            if (cfg_chg) begin
                pos  <= '0;
                wcnt <= '0;
            end else if (chk) begin
                pos  <= (pos + 4'd1 >= code.len) ? '0 : pos + 4'd1;
                wcnt <= win_end ? '0 : wcnt + 1'b1;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            DET_SEARCH: if (win_done && any_hit)  st_nx = DET_FOUND;
            DET_FOUND:  if (win_done && !any_hit) st_nx = DET_SEARCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= DET_SEARCH;
        else
            st <= st_nx;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (st == DET_SEARCH && st_nx == DET_FOUND)
            irq <= 1'b1;
        else if (irq_clr)
            irq <= 1'b0;
    end

    assign det = (st == DET_FOUND);

endmodule

// File: rtl/lcode_top.sv
module lcode_top
    import lcode_pkg::*;
#(
    parameter int unsigned WINDOW = 2048,
    parameter int unsigned THRESH = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_framed,
    input  logic       cfg_flex,
    input  logic [3:0] cfg_up_len,
    input  logic [7:0] cfg_up_pat,
    input  logic [3:0] cfg_dn_len,
    input  logic [7:0] cfg_dn_pat,
    input  logic       tx_send_up,
    input  logic       tx_send_dn,
    input  logic       tx_in_bit,
    input  logic       tx_in_valid,
    input  logic       tx_in_fbit,
    output logic       tx_out_bit,
    output logic       tx_out_valid,
    input  logic       rx_bit,
    input  logic       rx_valid,
    input  logic       rx_fbit,
    output logic       up_det,
    output logic       dn_det,
    output logic       up_irq,
    output logic       dn_irq,
    input  logic       irq_clr_up,
    input  logic       irq_clr_dn
);
    lcode_t up_code, dn_code;

    assign up_code = cfg_flex ? lc_resolve(cfg_up_len, cfg_up_pat) : LC_UP_DEFAULT;
    assign dn_code = cfg_flex ? lc_resolve(cfg_dn_len, cfg_dn_pat) : LC_DN_DEFAULT;

    lcode_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .framed    (cfg_framed),
        .up_code   (up_code),
        .dn_code   (dn_code),
        .send_up   (tx_send_up),
        .send_dn   (tx_send_dn),
        .in_bit    (tx_in_bit),
        .in_valid  (tx_in_valid),
        .in_fbit   (tx_in_fbit),
        .out_bit   (tx_out_bit),
        .out_valid (tx_out_valid)
    );

    lcode_det #(.WINDOW(WINDOW), .THRESH(THRESH)) u_det_up (
        .clk     (clk),
        .rst_n   (rst_n),
        .framed  (cfg_framed),
        .code    (up_code),
        .bit_in  (rx_bit),
        .valid   (rx_valid),
        .fbit    (rx_fbit),
        .irq_clr (irq_clr_up),
        .det     (up_det),
        .irq     (up_irq)
    );

    lcode_det #(.WINDOW(WINDOW), .THRESH(THRESH)) u_det_dn (
        .clk     (clk),
        .rst_n   (rst_n),
        .framed  (cfg_framed),
        .code    (dn_code),
        .bit_in  (rx_bit),
        .valid   (rx_valid),
        .fbit    (rx_fbit),
        .irq_clr (irq_clr_dn),
        .det     (dn_det),
        .irq     (dn_irq)
    );

endmodule

// File: rtl/lcode_chk.sv
module lcode_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_framed,
    input logic tx_send_up,
    input logic tx_send_dn,
    input logic tx_in_bit,
    input logic tx_in_valid,
    input logic tx_in_fbit,
    input logic tx_out_bit,
    input logic tx_out_valid,
    input logic rx_valid,
    input logic up_det,
    input logic dn_det,
    input logic up_irq,
    input logic dn_irq,
    input logic irq_clr_up,
    input logic irq_clr_dn
);
    // R3
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> tx_out_valid == $past(tx_in_valid));

    // R3
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && !tx_send_up && !tx_send_dn) |=> tx_out_bit == $past(tx_in_bit));

    // R5
    fslot_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_framed && tx_in_fbit && tx_in_valid) |=> tx_out_bit == $past(tx_in_bit));

    // R6
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(up_det));

    // R6
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(dn_det));

    // R9
    up_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_det) |-> up_irq);

    // R9
    dn_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_det) |-> dn_irq);

    // R9
    up_irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_irq) |-> $rose(up_det));

    // R9
    up_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_irq) |-> $past(irq_clr_up));

    // R9
    dn_irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_irq) |-> $past(irq_clr_dn));

endmodule

bind lcode_top lcode_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_framed   (cfg_framed),
    .tx_send_up   (tx_send_up),
    .tx_send_dn   (tx_send_dn),
    .tx_in_bit    (tx_in_bit),
    .tx_in_valid  (tx_in_valid),
    .tx_in_fbit   (tx_in_fbit),
    .tx_out_bit   (tx_out_bit),
    .tx_out_valid (tx_out_valid),
    .rx_valid     (rx_valid),
    .up_det       (up_det),
    .dn_det       (dn_det),
    .up_irq       (up_irq),
    .dn_irq       (dn_irq),
    .irq_clr_up   (irq_clr_up),
    .irq_clr_dn   (irq_clr_dn)
);

// File: tb/tb_lcode_top.sv
module tb_lcode_top;

    localparam int WIN  = 2048;
    localparam int NVEC = 9;

    typedef struct packed {
        logic       flex;
        logic       framed;
        logic       fstream;
        logic       send_dn;
        logic [3:0] ulen;
        logic [7:0] upat;
        logic [3:0] dlen;
        logic [7:0] dpat;
        logic [3:0] off;
        logic [5:0] errs;
        logic       exp_up;
        logic       exp_dn;
    } vec_t;

    // flex framed fstream dn  ulen upat dlen dpat off errs up dn
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 4'd0, 8'h00, 4'd2, 6'd0,  1'b1, 1'b0}, // R1 R6
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 8'h00, 4'd0, 8'h00, 4'd1, 6'd20, 1'b0, 1'b1}, // R1 R6 at threshold
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 4'd0, 8'h00, 4'd4, 6'd21, 1'b0, 1'b0}, // R7
        '{1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h00, 4'd0, 8'h00, 4'd3, 6'd10, 1'b1, 1'b0}, // R5 framed
        '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h00, 4'd0, 8'h00, 4'd0, 6'd0,  1'b0, 1'b0}, // R5 unframed
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 8'h02, 4'd8, 8'hF0, 4'd1, 6'd0,  1'b1, 1'b0}, // R2
        '{1'b1, 1'b1, 1'b1, 1'b1, 4'd2, 8'h02, 4'd8, 8'hF0, 4'd7, 6'd5,  1'b0, 1'b1}, // R2 R5
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 8'h01, 4'd15, 8'hF0, 4'd0, 6'd0, 1'b1, 1'b0}, // R2 clamp low
        '{1'b1, 1'b0, 1'b0, 1'b1, 4'd0, 8'h01, 4'd15, 8'h0F, 4'd5, 6'd0, 1'b0, 1'b1}  // R2 clamp high
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_framed = 1'b0, cfg_flex = 1'b0;
    logic [3:0] cfg_up_len = '0, cfg_dn_len = '0;
    logic [7:0] cfg_up_pat = '0, cfg_dn_pat = '0;
    logic       tx_send_up = 1'b0, tx_send_dn = 1'b0;
    logic       tx_in_bit = 1'b0, tx_in_valid = 1'b0, tx_in_fbit = 1'b0;
    logic       tx_out_bit, tx_out_valid;
    logic       rx_bit = 1'b0, rx_valid = 1'b0, rx_fbit = 1'b0;
    logic       up_det, dn_det, up_irq, dn_irq;
    logic       irq_clr_up = 1'b0, irq_clr_dn = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    lcode_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_framed(cfg_framed), .cfg_flex(cfg_flex),
        .cfg_up_len(cfg_up_len), .cfg_up_pat(cfg_up_pat),
        .cfg_dn_len(cfg_dn_len), .cfg_dn_pat(cfg_dn_pat),
        .tx_send_up(tx_send_up), .tx_send_dn(tx_send_dn),
        .tx_in_bit(tx_in_bit), .tx_in_valid(tx_in_valid), .tx_in_fbit(tx_in_fbit),
        .tx_out_bit(tx_out_bit), .tx_out_valid(tx_out_valid),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .rx_fbit(rx_fbit),
        .up_det(up_det), .dn_det(dn_det), .up_irq(up_irq), .dn_irq(dn_irq),
        .irq_clr_up(irq_clr_up), .irq_clr_dn(irq_clr_dn)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(input logic [3:0] l);
        if (l < 2) return 2;
        if (l > 8) return 8;
        return int'(l);
    endfunction

    function automatic logic cbit(input int len, input logic [7:0] pat, input int idx);
        return pat[len - 1 - idx];
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_push(input logic b, input logic f);
        rx_bit   = b;
        rx_fbit  = f;
        rx_valid = 1'b1;
        @(negedge clk);
    endtask

    // sends code bits until the block has checked nchk of them
    task automatic send_stream(input int len, input logic [7:0] pat, input int off,
                               input int errs, input bit fstream, input int nchk);
        int  chk_n = 0;
        int  i = 0;
        int  k = 0;
        int  e = 0;
        logic isf;
        logic b;
        while (chk_n < nchk) begin
            isf = fstream && (i % 193 == 192);
            if (isf)
                b = 1'b1;
            else begin
                b = cbit(len, pat, (k + off) % len);
                if ((k % 90 == 5) && (e < errs)) begin
                    b = ~b;
                    e++;
                end
                k++;
            end
            rx_push(b, isf);
            if (!(cfg_framed && isf)) chk_n++;
            i++;
        end
        rx_valid = 1'b0;
        rx_fbit  = 1'b0;
    endtask

    task automatic tx_push(input logic b, input logic f, input logic exp, input string req);
        tx_in_bit   = b;
        tx_in_fbit  = f;
        tx_in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(req, "tx_out_bit", tx_out_bit, exp);
        check(req, "tx_out_valid", tx_out_valid, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        do_reset();
        check("R10", "up_det", up_det, 1'b0);
        check("R10", "dn_det", dn_det, 1'b0);
        check("R10", "up_irq", up_irq, 1'b0);
        check("R10", "dn_irq", dn_irq, 1'b0);
        check("R10", "tx_out_valid", tx_out_valid, 1'b0);
        check("R10", "tx_out_bit", tx_out_bit, 1'b0);

        // detection vectors: R1 R2 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int       ln;
            logic [7:0] pt;
            cfg_flex   = VECS[v].flex;
            cfg_framed = VECS[v].framed;
            cfg_up_len = VECS[v].ulen;
            cfg_up_pat = VECS[v].upat;
            cfg_dn_len = VECS[v].dlen;
            cfg_dn_pat = VECS[v].dpat;
            do_reset();
            if (!VECS[v].flex) begin
                ln = VECS[v].send_dn ? 3 : 5;
                pt = 8'h01;
            end else begin
                ln = VECS[v].send_dn ? eff_len(VECS[v].dlen) : eff_len(VECS[v].ulen);
                pt = VECS[v].send_dn ? VECS[v].dpat : VECS[v].upat;
            end
            send_stream(ln, pt, int'(VECS[v].off), int'(VECS[v].errs), VECS[v].fstream, WIN);
            check($sformatf("R6 vector %0d", v), "up_det", up_det, VECS[v].exp_up);
            check($sformatf("R6 vector %0d", v), "dn_det", dn_det, VECS[v].exp_dn);
            check($sformatf("R9 vector %0d", v), "up_irq", up_irq, VECS[v].exp_up);
        end

        // R6 decision only at window end; R8 withdrawal; R9 latch and clear
        cfg_flex = 1'b0; cfg_framed = 1'b0;
        do_reset();
        send_stream(5, 8'h01, 0, 0, 1'b0, WIN - 1);
        check("R6", "up_det before window end", up_det, 1'b0);
        send_stream(5, 8'h01, WIN - 1, 0, 1'b0, 1);
        check("R6", "up_det at window end", up_det, 1'b1);
        send_stream(5, 8'h01, 0, 0, 1'b0, WIN - 1);
        check("R8", "up_det held mid-window", up_det, 1'b1);
        send_stream(2, 8'h03, 0, 0, 1'b0, 1);
        send_stream(2, 8'h03, 0, 0, 1'b0, WIN);
        check("R8", "up_det after miss window", up_det, 1'b0);
        check("R9", "up_irq still latched", up_irq, 1'b1);
        irq_clr_up = 1'b1;
        @(negedge clk);
        irq_clr_up = 1'b0;
        check("R9", "up_irq after clear", up_irq, 1'b0);

        // R1 R3 transmit default loop-up
        do_reset();
        tx_send_up = 1'b1;
        for (int k = 0; k < 10; k++) tx_push(1'b1, 1'b0, (k % 5 == 4), "R1 R3 up");
        // R4 switch to loop-down restarts at its first bit
        tx_send_up = 1'b0; tx_send_dn = 1'b1;
        for (int k = 0; k < 6; k++) tx_push(1'b1, 1'b0, (k % 3 == 2), "R4 dn");
        // R3 both set: loop-up wins
        tx_send_up = 1'b1;
        for (int k = 0; k < 5; k++) tx_push(1'b1, 1'b0, (k == 4), "R3 priority");
        // R3 passthrough
        tx_send_up = 1'b0; tx_send_dn = 1'b0;
        tx_push(1'b1, 1'b0, 1'b1, "R3 pass");
        tx_push(1'b0, 1'b0, 1'b0, "R3 pass");

        // R5 framed: framing slot passes and does not advance the code
        cfg_framed = 1'b1;
        tx_send_up = 1'b1;
        tx_push(1'b0, 1'b0, 1'b0, "R5 framed");
        tx_push(1'b0, 1'b0, 1'b0, "R5 framed");
        tx_push(1'b1, 1'b1, 1'b1, "R5 framed slot");
        tx_push(1'b1, 1'b0, 1'b0, "R5 framed");
        tx_push(1'b1, 1'b0, 1'b0, "R5 framed");
        tx_push(1'b1, 1'b0, 1'b1, "R5 framed");
        // R5 unframed: strobe ignored, code covers the slot
        cfg_framed = 1'b0;
        tx_send_up = 1'b0;
        tx_push(1'b0, 1'b0, 1'b0, "R5 unframed idle");
        tx_send_up = 1'b1;
        tx_push(1'b1, 1'b1, 1'b0, "R5 unframed");

        // R2 R4 programmed code and restart on pattern change
        tx_send_up = 1'b0;
        cfg_flex   = 1'b1;
        cfg_up_len = 4'd4;
        cfg_up_pat = 8'h08;
        tx_push(1'b0, 1'b0, 1'b0, "R2 idle");
        tx_send_up = 1'b1;
        tx_push(1'b0, 1'b0, 1'b1, "R2 flex");
        tx_push(1'b0, 1'b0, 1'b0, "R2 flex");
        tx_push(1'b0, 1'b0, 1'b0, "R2 flex");
        cfg_up_pat = 8'h0C;
        tx_push(1'b0, 1'b0, 1'b1, "R4 restart");
        tx_push(1'b0, 1'b0, 1'b1, "R4 restart");
        tx_push(1'b0, 1'b0, 1'b0, "R4 restart");
        tx_push(1'b0, 1'b0, 1'b0, "R4 restart");
        tx_push(1'b0, 1'b0, 1'b1, "R2 wrap");
        tx_send_up  = 1'b0;
        tx_in_valid = 1'b0;
        @(negedge clk);
        check("R3", "tx_out_valid after idle", tx_out_valid, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule